// File: doc/BRIEF.md
# Cropping Frame Buffer with VGA Readout

This block sits between a tile-based video generator and a VGA monitor. The generator delivers one pixel at a time as a 6-bit palette index, with its column and source line number, on its own pixel clock. The block keeps only the middle band of source lines and drops a fixed number of lines at the top and at the bottom. It stores the indices, not colours, in a dual-port memory. The memory's read side is clocked by an unrelated display clock.

On the display side a raster timing generator scans a VGA frame. Each stored pixel is shown as a 2x2 block, so the image is doubled in width and height. The enlarged image is centred in the active area and surrounded by black. A registered 64-entry palette turns each index into 15-bit RGB. Sync is delayed by the same number of registers as the memory read and the palette, so sync and colour stay aligned at the pins.

The default parameters give a reduced geometry that elaborates quickly: 32x24 source, 4 lines cropped at each end, and a 100x48 display raster. The full configuration uses 256x240 with 8 cropped lines, and 640x480 timing with 800 clocks per line and 525 lines.

Top module: `crop_fb_vga`

## Requirements
- R1: A write with source line y in [CROP, SRC_H-CROP) and column x stores wr_pix at stored line y-CROP. That pixel is then shown as a 2x2 block at display column H_OFF+2x and line V_OFF+2(y-CROP), where H_OFF=(H_ACT-2*SRC_W)/2 and V_OFF=(V_ACT-2*(SRC_H-2*CROP))/2.
- R2: A write whose line is below CROP, or at or above SRC_H-CROP (including values beyond SRC_H), changes no stored pixel.
- R3: Each display line lasts H_ACT+H_FP+H_SW+H_BP clocks. Position 0 is the first active clock. hsync_n is low exactly for positions [H_ACT+H_FP, H_ACT+H_FP+H_SW).
- R4: Each frame has V_ACT+V_FP+V_SW+V_BP lines. vsync_n is low for the whole of lines [V_ACT+V_FP, V_ACT+V_FP+V_SW).
- R5: rgb is zero at every position outside the centred image, and this includes all blanking positions.
- R6: Inside the image, rgb = {R,G,B} with 5 bits per channel. For index i, R={i[5:4],i[5:4],i[5]}, G={i[3:2],i[3:2],i[3]} and B={i[1:0],i[1:0],i[1]}.
- R7: rgb, hsync_n and vsync_n all describe the same raster position. Position (0,0) appears on the outputs after the second rising vid_clk edge that follows the release of vid_rst.
- R8: While vid_rst is high, hsync_n=1, vsync_n=1 and rgb=0.
- R9: Writes that arrive while the display is scanning update the memory. Once the writes stop, the next full frame shows the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Generator pixel clock |
| wr_rst | input | 1 | Synchronous active-high reset, write side |
| wr_valid | input | 1 | Pixel qualifier |
| wr_x | input | $clog2(SRC_W) | Source column |
| wr_y | input | $clog2(SRC_H) | Source line number |
| wr_pix | input | 6 | Palette index |
| vid_clk | input | 1 | Display pixel clock |
| vid_rst | input | 1 | Synchronous active-high reset, display side |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| rgb | output | 15 | Colour, red in bits 14:10, blue in bits 4:0 |

## Verification
Two things can fall in the same cycle: a generator write into the memory, and a display read of the memory while the raster is running. The bench provokes this by rewriting every stored pixel with a second pattern while the display scans. Throughout the rewrite it keeps checking sync timing on every clock, and it checks that the output is black outside the image. Once the rewrite has ended, it waits for the next frame boundary and compares every displayed pixel of that frame against its own shadow of the second pattern.

// File: rtl/cfv_pkg.sv
package cfv_pkg;

    localparam int IDX_W = 6;

    typedef logic [IDX_W-1:0] pal_idx_t;

    typedef struct packed {
        logic [4:0] r;
        logic [4:0] g;
        logic [4:0] b;
    } rgb15_t;

    // Raster flags carried alongside the memory read
    typedef struct packed {
        logic hs_n;
        logic vs_n;
        logic img;
    } vflag_t;

    localparam vflag_t FLAG_IDLE = '{hs_n: 1'b1, vs_n: 1'b1, img: 1'b0};

    // Two-bit channel code widened to five bits by repetition
    function automatic logic [4:0] widen2(input logic [1:0] c);
        return {c, c, c[1]};
    endfunction

    function automatic rgb15_t pal_lookup(input pal_idx_t i);
        rgb15_t c;
        c.r = widen2(i[5:4]);
        c.g = widen2(i[3:2]);
        c.b = widen2(i[1:0]);
        return c;
    endfunction

endpackage

// File: rtl/cfv_writer.sv
module cfv_writer
    import cfv_pkg::*;
#(
    parameter int SRC_W = 32,
    parameter int SRC_H = 24,
    parameter int CROP  = 4,
    parameter int XW    = 5,
    parameter int YW    = 5,
    parameter int AW    = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid,
    input  logic [XW-1:0]   x,
    input  logic [YW-1:0]   y,
    input  pal_idx_t        pix,
    output logic            we,
    output logic [AW-1:0]   waddr,
    output pal_idx_t        wdata
);
    localparam int Y_LO = CROP;
    localparam int Y_HI = SRC_H - CROP;

    logic keep;
    logic [31:0] line_idx;

    always_comb begin
        keep     = valid && (32'(y) >= Y_LO) && (32'(y) < Y_HI) && (32'(x) < SRC_W);
        line_idx = 32'(y) - 32'(Y_LO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            we    <= 1'b0;
            waddr <= '0;
            wdata <= '0;
        end else begin
            we    <= keep;
            waddr <= AW'(line_idx * 32'(SRC_W) + 32'(x));
            wdata <= pix;
        end
    end

    // R2: a line outside the kept band never produces a memory write
    p_crop_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (valid && ((32'(y) < Y_LO) || (32'(y) >= Y_HI))) |=> !we);

    // R1: every accepted write lands inside the stored image
    p_addr_range_r1: assert property (@(posedge clk) disable iff (rst)
        we |-> (32'(waddr) < SRC_W * (SRC_H - 2 * CROP)));

endmodule

// File: rtl/cfv_dpram.sv
module cfv_dpram #(
    parameter int DW    = 6,
    parameter int DEPTH = 512,
    parameter int AW    = 9
) (
    input  logic            wr_clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [DW-1:0]   wdata,
    input  logic            rd_clk,
    input  logic [AW-1:0]   raddr,
    output logic [DW-1:0]   rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/cfv_timing.sv
module cfv_timing
    import cfv_pkg::*;
#(
    parameter int H_ACT    = 80,
    parameter int H_FP     = 4,
    parameter int H_SW     = 8,
    parameter int H_BP     = 8,
    parameter int V_ACT    = 40,
    parameter int V_FP     = 2,
    parameter int V_SW     = 2,
    parameter int V_BP     = 4,
    parameter int SRC_W    = 32,
    parameter int IMG_W    = 64,
    parameter int IMG_H    = 32,
    parameter int SCALE_LG = 1,
    parameter int AW       = 9
) (
    input  logic            clk,
    input  logic            rst,
    output vflag_t          flags,
    output logic [AW-1:0]   rd_addr
);
    localparam int HT     = H_ACT + H_FP + H_SW + H_BP;
    localparam int VT     = V_ACT + V_FP + V_SW + V_BP;
    localparam int HCW    = $clog2(HT);
    localparam int VCW    = $clog2(VT);
    localparam int HS_BEG = H_ACT + H_FP;
    localparam int HS_END = HS_BEG + H_SW;
    localparam int VS_BEG = V_ACT + V_FP;
    localparam int VS_END = VS_BEG + V_SW;
    localparam int H_OFF  = (H_ACT - IMG_W) / 2;
    localparam int V_OFF  = (V_ACT - IMG_H) / 2;

    logic [HCW-1:0] hcnt;
    logic [VCW-1:0] vcnt;
    logic           h_last, v_last, h_in, v_in;
    logic [HCW-1:0] col;
    logic [VCW-1:0] row;

    assign h_last = (hcnt == HCW'(HT - 1));
    assign v_last = (vcnt == VCW'(VT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (h_last) begin
            hcnt <= '0;
            vcnt <= v_last ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    always_comb begin
        flags.hs_n = !((hcnt >= HCW'(HS_BEG)) && (hcnt < HCW'(HS_END)));
        flags.vs_n = !((vcnt >= VCW'(VS_BEG)) && (vcnt < VCW'(VS_END)));
        h_in       = (hcnt >= HCW'(H_OFF)) && (32'(hcnt) < H_OFF + IMG_W);
        v_in       = (vcnt >= VCW'(V_OFF)) && (32'(vcnt) < V_OFF + IMG_H);
        flags.img  = h_in && v_in;
        col        = (hcnt - HCW'(H_OFF)) >> SCALE_LG;
        row        = (vcnt - VCW'(V_OFF)) >> SCALE_LG;
        rd_addr    = flags.img ? AW'(32'(row) * 32'(SRC_W) + 32'(col)) : '0;
    end

    // R3: line counter steps by one inside a line
    p_hstep_r3: assert property (@(posedge clk) disable iff (rst)
        !h_last |=> (hcnt == $past(hcnt) + 1'b1));

    // R4: line number advances and wraps at the end of each line
    p_vstep_r4: assert property (@(posedge clk) disable iff (rst)
        h_last |=> (hcnt == '0) &&
                   (vcnt == ($past(v_last) ? '0 : $past(vcnt) + 1'b1)));

    // R5: the image window lies inside the active area
    p_img_active_r5: assert property (@(posedge clk) disable iff (rst)
        flags.img |-> ((32'(hcnt) < H_ACT) && (32'(vcnt) < V_ACT)));

endmodule

// File: rtl/cfv_palette.sv
module cfv_palette
    import cfv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  pal_idx_t idx,
    output rgb15_t   color
);
    localparam int ENTRIES = 1 << IDX_W;

    rgb15_t rom [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_rom
        assign rom[g] = pal_lookup(pal_idx_t'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) color <= '0;
        else     color <= en ? rom[idx] : '0;
    end

endmodule

// File: rtl/crop_fb_vga.sv
module crop_fb_vga
    import cfv_pkg::*;
#(
    parameter int SRC_W    = 32,
    parameter int SRC_H    = 24,
    parameter int CROP     = 4,
    parameter int SCALE_LG = 1,
    parameter int H_ACT    = 80,
    parameter int H_FP     = 4,
    parameter int H_SW     = 8,
    parameter int H_BP     = 8,
    parameter int V_ACT    = 40,
    parameter int V_FP     = 2,
    parameter int V_SW     = 2,
    parameter int V_BP     = 4,
    localparam int XW      = $clog2(SRC_W),
    localparam int YW      = $clog2(SRC_H)
) (
    input  logic            wr_clk,
    input  logic            wr_rst,
    input  logic            wr_valid,
    input  logic [XW-1:0]   wr_x,
    input  logic [YW-1:0]   wr_y,
    input  logic [5:0]      wr_pix,
    input  logic            vid_clk,
    input  logic            vid_rst,
    output logic            hsync_n,
    output logic            vsync_n,
    output logic [14:0]     rgb
);
    localparam int ST_H  = SRC_H - 2 * CROP;
    localparam int DEPTH = SRC_W * ST_H;
    localparam int AW    = $clog2(DEPTH);
    localparam int IMG_W = SRC_W << SCALE_LG;
    localparam int IMG_H = ST_H << SCALE_LG;

    logic          we;
    logic [AW-1:0] waddr;
    pal_idx_t      wdata;
    logic [AW-1:0] raddr;
    pal_idx_t      rdata;
    vflag_t        f0, f1, f2;
    rgb15_t        color;

    cfv_writer #(
        .SRC_W(SRC_W), .SRC_H(SRC_H), .CROP(CROP),
        .XW(XW), .YW(YW), .AW(AW)
    ) u_writer (
        .clk(wr_clk), .rst(wr_rst), .valid(wr_valid),
        .x(wr_x), .y(wr_y), .pix(wr_pix),
        .we(we), .waddr(waddr), .wdata(wdata)
    );

    cfv_dpram #(.DW(IDX_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wdata),
        .rd_clk(vid_clk), .raddr(raddr), .rdata(rdata)
    );

    cfv_timing #(
        .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
        .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP),
        .SRC_W(SRC_W), .IMG_W(IMG_W), .IMG_H(IMG_H),
        .SCALE_LG(SCALE_LG), .AW(AW)
    ) u_timing (
        .clk(vid_clk), .rst(vid_rst), .flags(f0), .rd_addr(raddr)
    );

    // Flags follow the memory read (stage 1) and the palette (stage 2)
    always_ff @(posedge vid_clk) begin
        if (vid_rst) begin
            f1 <= FLAG_IDLE;
            f2 <= FLAG_IDLE;
        end else begin
            f1 <= f0;
            f2 <= f1;
        end
    end

    cfv_palette u_pal (
        .clk(vid_clk), .rst(vid_rst), .en(f1.img), .idx(rdata), .color(color)
    );

    assign hsync_n = f2.hs_n;
    assign vsync_n = f2.vs_n;
    assign rgb     = color;

    // R5: colour is black whenever the aligned position is outside the image
    p_black_outside_r5: assert property (@(posedge vid_clk) disable iff (vid_rst)
        !f2.img |-> (rgb == '0));

    // R7: sync pins trail the raster generator by two clocks
    p_hs_lat_r7: assert property (@(posedge vid_clk) disable iff (vid_rst)
        hsync_n == $past(f0.hs_n, 2));

    p_vs_lat_r7: assert property (@(posedge vid_clk) disable iff (vid_rst)
        vsync_n == $past(f0.vs_n, 2));

endmodule

// File: tb/crop_fb_vga_tb_top.sv
module crop_fb_vga_tb_top;

    localparam int SRC_W = 32, SRC_H = 24, CROP = 4, ST_H = SRC_H - 2 * CROP;
    localparam int H_ACT = 80, H_FP = 4, H_SW = 8, H_BP = 8;
    localparam int V_ACT = 40, V_FP = 2, V_SW = 2, V_BP = 4;
    localparam int HT = H_ACT + H_FP + H_SW + H_BP;
    localparam int VT = V_ACT + V_FP + V_SW + V_BP;
    localparam int FRAME = HT * VT;
    localparam int IMG_W = 2 * SRC_W, IMG_H = 2 * ST_H;
    localparam int H_OFF = (H_ACT - IMG_W) / 2, V_OFF = (V_ACT - IMG_H) / 2;

    // Table rows: [16:12] line, [11:7] column, [6:1] index, [0] expected to be kept
    localparam logic [16:0] VEC [8] = '{
        {5'd3,  5'd0,  6'h3F, 1'b0},
        {5'd4,  5'd0,  6'h15, 1'b1},
        {5'd19, 5'd31, 6'h2A, 1'b1},
        {5'd20, 5'd5,  6'h3C, 1'b0},
        {5'd0,  5'd10, 6'h01, 1'b0},
        {5'd23, 5'd31, 6'h30, 1'b0},
        {5'd30, 5'd2,  6'h0F, 1'b0},
        {5'd10, 5'd16, 6'h33, 1'b1}
    };

    logic        vid_clk = 1'b0, wr_clk = 1'b0;
    logic        vid_rst = 1'b1, wr_rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [4:0]  wr_x = '0, wr_y = '0;
    logic [5:0]  wr_pix = '0;
    logic        hsync_n, vsync_n;
    logic [14:0] rgb;

    always #10 vid_clk = ~vid_clk;
    always #18 wr_clk  = ~wr_clk;

    crop_fb_vga dut_i (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid),
        .wr_x(wr_x), .wr_y(wr_y), .wr_pix(wr_pix),
        .vid_clk(vid_clk), .vid_rst(vid_rst),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .rgb(rgb)
    );

    int checks = 0, fails = 0;
    int e = 0;
    int pix_err = 0;
    int first_hs_fall = -1;
    bit chk_on = 0, pix_chk = 0, done = 0;
    logic [5:0]  shadow [ST_H][SRC_W];
    logic [14:0] cap    [ST_H][SRC_W];

    function automatic int chan(int c);
        return 10 * c + (c >> 1);
    endfunction

    function automatic int exp_rgb(int i);
        return (chan((i >> 4) & 3) << 10) | (chan((i >> 2) & 3) << 5) | chan(i & 3);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic wr_px(int x, int y, int p);
        @(negedge wr_clk);
        wr_valid = 1'b1;
        wr_x     = 5'(x);
        wr_y     = 5'(y);
        wr_pix   = 6'(p);
    endtask

    task automatic wr_idle();
        @(negedge wr_clk);
        wr_valid = 1'b0;
    endtask

    always @(posedge vid_clk) begin
        if (vid_rst) e <= 0;
        else         e <= e + 1;
    end

    // Output model: after edge e the pins describe raster position e-2
    always @(negedge vid_clk) begin
        if (chk_on && !vid_rst && e >= 2) begin
            automatic int p  = (e - 2) % FRAME;
            automatic int h  = p % HT;
            automatic int v  = p / HT;
            automatic bit hs = !((h >= H_ACT + H_FP) && (h < H_ACT + H_FP + H_SW));
            automatic bit vs = !((v >= V_ACT + V_FP) && (v < V_ACT + V_FP + V_SW));
            automatic bit im = (h >= H_OFF) && (h < H_OFF + IMG_W) &&
                               (v >= V_OFF) && (v < V_OFF + IMG_H);
            chk(hsync_n == hs, "R3", "hsync_n", int'(hsync_n), int'(hs));
            chk(vsync_n == vs, "R4", "vsync_n", int'(vsync_n), int'(vs));
            if (first_hs_fall < 0 && !hsync_n) first_hs_fall = e;
            if (!im) begin
                chk(rgb == 15'd0, "R5", "rgb outside image", int'(rgb), 0);
            end else if (pix_chk) begin
                automatic int sx = (h - H_OFF) / 2;
                automatic int sy = (v - V_OFF) / 2;
                automatic int ex = exp_rgb(int'(shadow[sy][sx]));
                if (int'(rgb) != ex) pix_err++;
                chk(int'(rgb) == ex, "R6", "rgb in image", int'(rgb), ex);
                if (((h - H_OFF) % 2 == 0) && ((v - V_OFF) % 2 == 0)) cap[sy][sx] = rgb;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge vid_clk);
        chk(0, "R9", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // R8: idle outputs during reset
        repeat (5) @(posedge vid_clk);
        @(negedge vid_clk);
        chk(hsync_n == 1'b1, "R8", "hsync_n in reset", int'(hsync_n), 1);
        chk(vsync_n == 1'b1, "R8", "vsync_n in reset", int'(vsync_n), 1);
        chk(rgb == 15'd0, "R8", "rgb in reset", int'(rgb), 0);

        @(negedge wr_clk);
        wr_rst = 1'b0;

        // Baseline frame: all source lines, only the middle band is kept (R1, R2)
        for (int y = 0; y < SRC_H; y++) begin
            for (int x = 0; x < SRC_W; x++) begin
                wr_px(x, y, (x * 3 + y * 5) & 63);
                if (y >= CROP && y < SRC_H - CROP) shadow[y - CROP][x] = 6'((x * 3 + y * 5) & 63);
            end
        end

        // Table of single-pixel writes at the crop boundaries
        for (int i = 0; i < 8; i++) begin
            wr_px(int'(VEC[i][11:7]), int'(VEC[i][16:12]), int'(VEC[i][6:1]));
            if (VEC[i][0]) shadow[int'(VEC[i][16:12]) - CROP][VEC[i][11:7]] = VEC[i][6:1];
        end
        wr_idle();
        repeat (4) @(negedge wr_clk);

        @(negedge vid_clk);
        vid_rst = 1'b0;
        chk_on  = 1;
        pix_chk = 1;
        wait (e >= FRAME + 2);
        @(negedge vid_clk);
        pix_chk = 0;

        // R7: first sync pulse starts two clocks after its raster position
        chk(first_hs_fall == H_ACT + H_FP + 2, "R7", "first hsync fall edge", first_hs_fall,
            H_ACT + H_FP + 2);

        for (int i = 0; i < 8; i++) begin
            if (VEC[i][0]) begin
                automatic int sy = int'(VEC[i][16:12]) - CROP;
                automatic int ex = exp_rgb(int'(VEC[i][6:1]));
                chk(int'(cap[sy][VEC[i][11:7]]) == ex, "R1", "kept table pixel",
                    int'(cap[sy][VEC[i][11:7]]), ex);
            end else begin
                chk(pix_err == 0, "R2", "dropped line left frame intact", pix_err, 0);
            end
        end

        // R9: rewrite the image while the raster keeps running
        for (int y = 0; y < SRC_H; y++) begin
            for (int x = 0; x < SRC_W; x++) begin
                wr_px(x, y, (x * 7 + y + 11) & 63);
                if (y >= CROP && y < SRC_H - CROP) shadow[y - CROP][x] = 6'((x * 7 + y + 11) & 63);
            end
        end
        wr_idle();
        repeat (4) @(negedge wr_clk);

        // Arm the pixel check for the start of the next frame
        do @(posedge vid_clk); while (((e - 2) % FRAME) != FRAME - 1);
        pix_err = 0;
        pix_chk = 1;
        repeat (FRAME) @(posedge vid_clk);
        @(negedge vid_clk);
        pix_chk = 0;
        chk(pix_err == 0, "R9", "mismatches in frame after rewrite", pix_err, 0);
        chk(int'(cap[0][0]) == exp_rgb((0 * 7 + CROP + 11) & 63), "R9", "corner pixel",
            int'(cap[0][0]), exp_rgb((CROP + 11) & 63));
        chk(int'(cap[ST_H - 1][SRC_W - 1]) ==
            exp_rgb(((SRC_W - 1) * 7 + (SRC_H - CROP - 1) + 11) & 63), "R9", "far corner pixel",
            int'(cap[ST_H - 1][SRC_W - 1]),
            exp_rgb(((SRC_W - 1) * 7 + (SRC_H - CROP - 1) + 11) & 63));

        finish_run();
    end

endmodule